// File: doc/BRIEF.md
# Framebuffer Write Snooper with RAM-Size-Dependent Window

This block sits beside a 68000-style asynchronous CPU bus and watches for CPU writes that fall inside the main display framebuffer. It turns each such bus write into one or two byte-wide write requests for a separate video RAM, so that a display engine always holds a copy of the screen. Nothing on the CPU bus is driven. The block only observes it.

The framebuffer does not sit at a fixed address. It is placed a fixed distance below the top of installed memory, and a 3-bit jumper setting tells the block how much memory is fitted. Every bus input is brought into the local clock domain through a two-stage synchroniser. A write is recognised on the cycle in which the qualified strobe becomes active. At that moment the block computes the window offset and latches it together with the data. It then issues one request per enabled byte lane, upper lane first, into a small queue. A downstream video RAM arbiter drains that queue through a valid/ready handshake.

Top module: `fb_snoop`

## Requirements
- R1: While reset is high, and in the cycle after it, `req_valid` is 0. After reset, with an idle bus, no request appears.
- R2: The window base is (ram_size + 1) × 0x80000 − 0x5900, taking the CPU byte address as {bus_addr, 0}. Setting 7 gives base 0x3FA700, setting 3 gives 0x1FA700, setting 1 gives 0x0FA700 and setting 0 gives 0x07A700. A write to the base produces offset 0. An address that is the base for some other setting is not snooped.
- R3: A write at any byte address below the base produces no request.
- R4: The window is 21888 bytes long. The word at base + 21886 produces offsets 21886 and 21887. The word at base + 21888 produces no request. Every request address is below 21888.
- R5: When both data strobes are low, two requests are issued in this order: first offset N (even) carrying bus_data[15:8], then offset N+1 carrying bus_data[7:0].
- R6: When only the upper strobe is low, the block issues one request at the even offset with bus_data[15:8]. When only the lower strobe is low, it issues one request at the odd offset with bus_data[7:0].
- R7: A bus cycle with bus_rnw = 1 (read) produces no request.
- R8: The alternate framebuffer at (ram_size + 1) × 0x80000 − 0xD900 is not snooped.
- R9: A strobe held low for many clocks still yields exactly one request per enabled lane.
- R10: Address and data are captured when the strobe is first detected. Changes on the bus afterwards, while the strobes stay low, do not alter the requests.
- R11: While `req_ready` is 0, `req_valid` stays high and `req_addr`/`req_data` hold their values. Queued requests are delivered in issue order.
- R12: Data strobes low while `bus_as_n` is high produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local (pixel) clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 23 | CPU word address, bits 23..1 |
| bus_data | input | 16 | CPU data bus |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_uds_n | input | 1 | Upper data strobe (bits 15..8), active low |
| bus_lds_n | input | 1 | Lower data strobe (bits 7..0), active low |
| ram_size | input | 3 | Installed memory setting, top = (value + 1) × 0x80000 |
| req_ready | input | 1 | Arbiter accepts the presented request |
| req_valid | output | 1 | A byte request is presented |
| req_addr | output | 15 | Video RAM byte offset |
| req_data | output | 8 | Byte to write |

## Verification
The bench targets the window edges for several memory settings. These are the byte just below the base, the last word inside the window and the first word past it. An off-by-one in the base or length shows up there as an extra or a missing request. The alternate-buffer address and an address that is only valid under another setting expose a decoder that ignores the setting or also decodes the alternate buffer. Held strobes and a bus that changes mid-cycle catch level-triggered capture, which floods the queue with duplicates, and capture that is not latched, which writes the later values. A stalled arbiter and single-lane writes reveal swapped lanes, a wrong odd/even placement, or a queue that reorders or drops entries.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int unsigned VA_W   = 15;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [VA_W-1:0]   addr;
    logic [BYTE_W-1:0] data;
  } vreq_t;

  localparam int unsigned VREQ_W = $bits(vreq_t);
endpackage

// File: rtl/fbs_sync.sv
module fbs_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fbs_window.sv
module fbs_window
  import fbs_pkg::*;
#(
  parameter int unsigned WORD_ADDR_W = 23,
  parameter int unsigned SIZE_W      = 3,
  parameter int unsigned BANK_SHIFT  = 19,
  parameter int unsigned FB_GAP      = 32'h5900,
  parameter int unsigned FB_BYTES    = 21888
) (
  input  logic [SIZE_W-1:0]      size_sel,
  input  logic [WORD_ADDR_W-1:0] word_addr,
  output logic                   hit,
  output logic [VA_W-1:0]        offset
);
  localparam int unsigned BA_W = WORD_ADDR_W + 1;
  localparam int unsigned EW   = BA_W + 1;

  logic [EW-1:0] size_ext;
  logic [EW-1:0] ram_top;
  logic [EW-1:0] base;
  logic [EW-1:0] byte_addr;
  logic [EW-1:0] diff;

  always_comb begin
    size_ext  = EW'(size_sel) + EW'(1);
    ram_top   = size_ext << BANK_SHIFT;
    base      = ram_top - EW'(FB_GAP);
    byte_addr = {1'b0, word_addr, 1'b0};
    diff      = byte_addr - base;
    hit       = (byte_addr >= base) && (diff < EW'(FB_BYTES));
    offset    = diff[VA_W-1:0];
  end
endmodule

// File: rtl/fbs_capture.sv
module fbs_capture
  import fbs_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n,
  input  logic              rnw,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              hit,
  input  logic [VA_W-1:0]   offset,
  input  logic [DATA_W-1:0] data,
  input  logic              full,
  output logic              push,
  output vreq_t             push_req
);
  logic              act, act_q, detect;
  logic              pend_hi, pend_lo;
  logic              issue_hi, issue_lo;
  logic [VA_W-1:0]   lat_off;
  logic [DATA_W-1:0] lat_data;

  always_comb begin
    act      = !as_n && !rnw && (!uds_n || !lds_n);
    detect   = act && !act_q;
    issue_hi = pend_hi && !full;
    issue_lo = !pend_hi && pend_lo && !full;
    push     = issue_hi || issue_lo;
    if (issue_hi) begin
      push_req.addr = lat_off;
      push_req.data = lat_data[DATA_W-1 -: BYTE_W];
    end else begin
      push_req.addr = lat_off + VA_W'(1);
      push_req.data = lat_data[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      pend_hi  <= 1'b0;
      pend_lo  <= 1'b0;
      lat_off  <= '0;
      lat_data <= '0;
    end else begin
      act_q <= act;
      if (detect && hit) begin
        pend_hi  <= !uds_n;
        pend_lo  <= !lds_n;
        lat_off  <= offset;
        lat_data <= data;
      end else if (issue_hi) begin
        pend_hi <= 1'b0;
      end else if (issue_lo) begin
        pend_lo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbs_fifo.sv
module fbs_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             wr_en, load;

  always_comb begin
    full  = (count == CNT_W'(DEPTH));
    wr_en = push && !full;
    load  = (count != '0) && (!out_valid || out_ready);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + PTR_W'(1);
      if (load) begin
        rd_ptr    <= rd_ptr + PTR_W'(1);
        out_data  <= mem[rd_ptr];
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      count <= count + CNT_W'(wr_en) - CNT_W'(load);
    end
  end
endmodule

// File: rtl/fb_snoop.sv
module fb_snoop
  import fbs_pkg::*;
#(
  parameter int unsigned WORD_ADDR_W = 23,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SIZE_W      = 3,
  parameter int unsigned BANK_SHIFT  = 19,
  parameter int unsigned FB_GAP      = 32'h5900,
  parameter int unsigned FB_BYTES    = 21888,
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WORD_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]      bus_data,
  input  logic                   bus_rnw,
  input  logic                   bus_as_n,
  input  logic                   bus_uds_n,
  input  logic                   bus_lds_n,
  input  logic [SIZE_W-1:0]      ram_size,
  input  logic                   req_ready,
  output logic                   req_valid,
  output logic [VA_W-1:0]        req_addr,
  output logic [BYTE_W-1:0]      req_data
);
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned SYNC_W = SIZE_W + WORD_ADDR_W + DATA_W + CTL_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{(SYNC_W-CTL_W){1'b0}}, {CTL_W{1'b1}}};

  logic [SYNC_W-1:0]      sync_q;
  logic [SIZE_W-1:0]      s_size;
  logic [WORD_ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0]      s_data;
  logic                   s_rnw, s_as_n, s_uds_n, s_lds_n;
  logic                   win_hit;
  logic [VA_W-1:0]        win_off;
  logic                   q_full, q_push;
  vreq_t                  q_in, q_out;

  fbs_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ram_size, bus_addr, bus_data, bus_rnw, bus_as_n, bus_uds_n, bus_lds_n}),
    .q   (sync_q)
  );

  assign {s_size, s_addr, s_data, s_rnw, s_as_n, s_uds_n, s_lds_n} = sync_q;

  fbs_window #(
    .WORD_ADDR_W(WORD_ADDR_W), .SIZE_W(SIZE_W), .BANK_SHIFT(BANK_SHIFT),
    .FB_GAP(FB_GAP), .FB_BYTES(FB_BYTES)
  ) u_window (
    .size_sel  (s_size),
    .word_addr (s_addr),
    .hit       (win_hit),
    .offset    (win_off)
  );

  fbs_capture #(
    .DATA_W(DATA_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .as_n     (s_as_n),
    .rnw      (s_rnw),
    .uds_n    (s_uds_n),
    .lds_n    (s_lds_n),
    .hit      (win_hit),
    .offset   (win_off),
    .data     (s_data),
    .full     (q_full),
    .push     (q_push),
    .push_req (q_in)
  );

  fbs_fifo #(
    .W(VREQ_W), .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (q_push),
    .push_data (q_in),
    .full      (q_full),
    .out_ready (req_ready),
    .out_valid (req_valid),
    .out_data  (q_out)
  );

  assign req_addr = q_out.addr;
  assign req_data = q_out.data;
endmodule

// File: rtl/fb_snoop_chk.sv
module fb_snoop_chk #(
  parameter int unsigned FB_BYTES = 21888
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [14:0] req_addr,
  input logic [7:0]  req_data
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !req_valid);                                               // R1

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));   // R11

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> $stable(req_data));                  // R11

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (32'(req_addr) < FB_BYTES));                         // R4
endmodule

bind fb_snoop fb_snoop_chk #(.FB_BYTES(FB_BYTES)) u_fb_snoop_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_data  (req_data)
);

// File: tb/fb_snoop_bench.sv
`timescale 1ns/1ps
module fb_snoop_bench;
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_rnw = 1'b1, bus_as_n = 1'b1, bus_uds_n = 1'b1, bus_lds_n = 1'b1;
  logic [2:0]  ram_size = '0;
  logic        req_ready = 1'b1;
  logic        req_valid;
  logic [14:0] req_addr;
  logic [7:0]  req_data;

  always #2.5 clk = ~clk;

  fb_snoop u_fb_snoop (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rnw(bus_rnw), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .ram_size(ram_size), .req_ready(req_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int got_n = 0;
  logic [14:0] got_a [16];
  logic [7:0]  got_d [16];

  // collect accepted requests, sampled 1 ns after the falling edge
  initial forever begin
    @(negedge clk); #1;
    if (req_valid && req_ready && got_n < 16) begin
      got_a[got_n] = req_addr;
      got_d[got_n] = req_data;
      got_n++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [2:0] sz, input logic [23:0] ba, input logic [15:0] d,
                           input logic rnw, input logic as_n, input logic uds_n,
                           input logic lds_n, input int hold);
    @(negedge clk);
    ram_size = sz; bus_addr = ba[23:1]; bus_data = d;
    bus_rnw = rnw; bus_as_n = as_n; bus_uds_n = uds_n; bus_lds_n = lds_n;
    repeat (hold) @(negedge clk);
    bus_rnw = 1'b1; bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0]  tag;
    logic [2:0]  sz;
    logic [23:0] ba;
    logic [15:0] d;
    logic        rnw, as_n, uds_n, lds_n;
    logic [1:0]  n;
    logic [14:0] a0;
    logic [7:0]  d0;
    logic [14:0] a1;
    logic [7:0]  d1;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  3'd7, 24'h3FA700, 16'hA55A, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 15'h0000, 8'hA5, 15'h0001, 8'h5A}, // R2 R5
    '{4'd2,  3'd3, 24'h1FA700, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 15'h0000, 8'h12, 15'h0001, 8'h34}, // R2
    '{4'd2,  3'd0, 24'h07A700, 16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 15'h0000, 8'hBE, 15'h0001, 8'hEF}, // R2
    '{4'd3,  3'd7, 24'h3FA6FE, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 15'h0000, 8'h00, 15'h0000, 8'h00}, // R3
    '{4'd4,  3'd7, 24'h3FFC7E, 16'hC3D2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 15'h557E, 8'hC3, 15'h557F, 8'hD2}, // R4
    '{4'd4,  3'd7, 24'h3FFC80, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 15'h0000, 8'h00, 15'h0000, 8'h00}, // R4
    '{4'd6,  3'd4, 24'h27A900, 16'h9ABC, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 15'h0200, 8'h9A, 15'h0000, 8'h00}, // R6
    '{4'd6,  3'd4, 24'h27A902, 16'h9ABC, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 15'h0203, 8'hBC, 15'h0000, 8'h00}, // R6
    '{4'd7,  3'd7, 24'h3FA700, 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 15'h0000, 8'h00, 15'h0000, 8'h00}, // R7
    '{4'd8,  3'd7, 24'h3F2700, 16'h6666, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 15'h0000, 8'h00, 15'h0000, 8'h00}, // R8
    '{4'd12, 3'd1, 24'h0FA700, 16'h4242, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 15'h0000, 8'h00, 15'h0000, 8'h00}, // R12
    '{4'd2,  3'd1, 24'h0FA710, 16'h0102, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 15'h0010, 8'h01, 15'h0011, 8'h02}, // R2
    '{4'd2,  3'd7, 24'h1FA700, 16'h3C3C, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 15'h0000, 8'h00, 15'h0000, 8'h00}  // R2
  };

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired for R1..R12 run actual=%0d expected=0", WD_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(req_valid == 1'b0, "R1 valid during reset", req_valid, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    check(got_n == 0 && !req_valid, "R1 idle after reset", got_n, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      got_n = 0;
      bus_cycle(v.sz, v.ba, v.d, v.rnw, v.as_n, v.uds_n, v.lds_n, 6);
      check(got_n == int'(v.n), $sformatf("R%0d vec%0d count", v.tag, i), got_n, v.n);
      if (got_n == int'(v.n) && v.n >= 1)
        check(got_a[0] == v.a0 && got_d[0] == v.d0,
              $sformatf("R%0d vec%0d first", v.tag, i), {got_a[0], got_d[0]}, {v.a0, v.d0});
      if (got_n == int'(v.n) && v.n == 2)
        check(got_a[1] == v.a1 && got_d[1] == v.d1,
              $sformatf("R%0d vec%0d second", v.tag, i), {got_a[1], got_d[1]}, {v.a1, v.d1});
    end

    // R9: strobes held for 60 cycles
    got_n = 0;
    bus_cycle(3'd7, 24'h3FA720, 16'hDEAD, 1'b0, 1'b0, 1'b0, 1'b0, 60);
    check(got_n == 2, "R9 long strobe count", got_n, 2);

    // R10: bus changes after detection while strobes stay low
    got_n = 0;
    @(negedge clk);
    ram_size = 3'd7; bus_addr = 23'(24'h3FA740 >> 1); bus_data = 16'h1357;
    bus_rnw = 1'b0; bus_as_n = 1'b0; bus_uds_n = 1'b0; bus_lds_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_addr = 23'(24'h3FA800 >> 1); bus_data = 16'hFFFF;
    repeat (6) @(negedge clk);
    bus_rnw = 1'b1; bus_as_n = 1'b1; bus_uds_n = 1'b1; bus_lds_n = 1'b1;
    repeat (14) @(negedge clk);
    check(got_n == 2, "R10 latched count", got_n, 2);
    if (got_n == 2) begin
      check(got_a[0] == 15'h40 && got_d[0] == 8'h13, "R10 latched upper", {got_a[0], got_d[0]}, {15'h40, 8'h13});
      check(got_a[1] == 15'h41 && got_d[1] == 8'h57, "R10 latched lower", {got_a[1], got_d[1]}, {15'h41, 8'h57});
    end

    // R11: arbiter stalls, queue holds and keeps order
    got_n = 0;
    @(negedge clk); req_ready = 1'b0;
    bus_cycle(3'd7, 24'h3FA700, 16'hA55A, 1'b0, 1'b0, 1'b0, 1'b0, 6);
    bus_cycle(3'd7, 24'h3FA702, 16'h0F1E, 1'b0, 1'b0, 1'b0, 1'b0, 6);
    #1;
    check(req_valid && req_addr == 15'h0 && req_data == 8'hA5, "R11 stalled head",
          {req_valid, req_addr, req_data}, {1'b1, 15'h0, 8'hA5});
    repeat (5) @(negedge clk);
    #1;
    check(req_valid && req_addr == 15'h0 && req_data == 8'hA5, "R11 stalled hold",
          {req_valid, req_addr, req_data}, {1'b1, 15'h0, 8'hA5});
    @(negedge clk); req_ready = 1'b1;
    repeat (12) @(negedge clk);
    check(got_n == 4, "R11 drained count", got_n, 4);
    if (got_n == 4) begin
      check(got_a[0] == 15'h0 && got_d[0] == 8'hA5, "R11 order 0", {got_a[0], got_d[0]}, {15'h0, 8'hA5});
      check(got_a[1] == 15'h1 && got_d[1] == 8'h5A, "R11 order 1", {got_a[1], got_d[1]}, {15'h1, 8'h5A});
      check(got_a[2] == 15'h2 && got_d[2] == 8'h0F, "R11 order 2", {got_a[2], got_d[2]}, {15'h2, 8'h0F});
      check(got_a[3] == 15'h3 && got_d[3] == 8'h1E, "R11 order 3", {got_a[3], got_d[3]}, {15'h3, 8'h1E});
    end

    done = 1;
    summary();
    $finish;
  end
endmodule